// File: doc/BRIEF.md
# Virtual Token Slot Arbiter

This block decides when one station on a shared medium may start a frame, without any token ever being sent. Once a frame on the medium ends, every station splits the idle time that follows into equal slots and steps a common slot number. Each station owns one slot number. When the running number reaches its own, and that station has a frame waiting and hears no carrier, it gets a one-cycle transmit-right pulse. Every station follows the same count, so only one of them owns any given slot, and collisions are avoided.

The token passes along a fixed order. When a frame ends, the count starts again from the slot after the station that sent it, and does not go back to slot 1. The sender is known from timing alone: it is the owner of the slot in which carrier first appeared. The slot length is a count of microsecond ticks held in a register that can be loaded.

Top module: `vts_arbiter`

## Requirements
- R1: After reset `token_slot` is 0, `tx_grant` is low and no slot counting takes place until the first `frame_end` pulse; carrier before that pulse changes nothing.
- R2: A `frame_end` pulse starts counting at the successor of the last recorded sender; if no sender has been recorded since reset, the count starts at slot 1.
- R3: While counting and with no carrier, each slot lasts exactly `slot length` pulses of `tick`, and then `token_slot` moves to the next slot number.
- R4: The successor of slot k is k+1, except that any k greater than or equal to `stn_count` is followed by slot 1.
- R5: When a slot equal to `my_id` begins, and `pending` is high and `carrier` is low on the next clock, `tx_grant` is high for exactly that one clock.
- R6: No grant is given if `pending` is low or `carrier` is high on the clock after the own slot begins, or for any other slot; the slot then runs out and the count moves on.
- R7: Carrier seen while counting freezes `token_slot` and the slot timer, and records the current slot as the sender.
- R8: A `frame_end` after a busy period resumes counting at the sender's successor (after a frame in slot 2 the count runs 3, 4, ...).
- R9: The slot length register resets to SLOT_TICKS_RST (54 ticks, that is 54 µs with a 1 µs tick).
- R10: A `cfg_we` pulse with a nonzero `cfg_len` loads the slot length; a write of zero leaves the slot length unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_id | input | IDW | Slot number owned by this station |
| stn_count | input | IDW | Number of stations, the highest slot number |
| carrier | input | 1 | Medium busy |
| frame_end | input | 1 | One-cycle pulse at the end of a frame on the medium |
| pending | input | 1 | This station has a frame to send |
| tick | input | 1 | One-cycle pulse per microsecond |
| cfg_we | input | 1 | Load strobe for the slot length |
| cfg_len | input | LENW | New slot length in ticks |
| tx_grant | output | 1 | One-cycle transmit-right pulse |
| token_slot | output | IDW | Current virtual token slot, 0 before the first frame end |

## Verification
The hardest case to reach from the ports is a carrier that appears in the very clock after the station's own slot begins. Carrier then has to suppress the grant and record this station as the sender, all in one cycle. The bench waits at the falling edge on which `token_slot` first equals `my_id` and raises carrier right there, so it lands exactly in that window. Random traffic also moves `stn_count` below the running slot number, which forces the out-of-range wrap. A cycle-level model in the bench tracks every cycle of all of this.

// File: rtl/vts_pkg.sv
package vts_pkg;
   typedef enum logic [1:0] {
      VTS_SYNC  = 2'd0,
      VTS_COUNT = 2'd1,
      VTS_BUSY  = 2'd2
   } vts_state_e;
endpackage

// File: rtl/vts_slot_timer.sv
module vts_slot_timer #(
   parameter int LENW           = 8,
   parameter int SLOT_TICKS_RST = 54
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            run,
   input  logic            tick,
   input  logic            cfg_we,
   input  logic [LENW-1:0] cfg_len,
   output logic            slot_done
);
   localparam logic [LENW-1:0] LEN_RST = LEN_RST_CALC();

   function automatic logic [LENW-1:0] LEN_RST_CALC();
      return SLOT_TICKS_RST[LENW-1:0];
   endfunction

   logic [LENW-1:0] slot_len;
   logic [LENW-1:0] tick_cnt;
   logic            at_last;

   always_ff @(posedge clk) begin
      if (!rst_n)
         slot_len <= LEN_RST;
      else if (cfg_we && (cfg_len != '0))
         slot_len <= cfg_len;
   end

   assign at_last   = ({1'b0, tick_cnt} + 1'b1) >= {1'b0, slot_len};
   assign slot_done = run && tick && at_last;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         tick_cnt <= '0;
      else if (run && tick)
         tick_cnt <= at_last ? '0 : tick_cnt + 1'b1;
   end

   // R10
   zero_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_len == '0) |=> $stable(slot_len));
   // R7
   timer_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clr) |=> $stable(tick_cnt));
endmodule

// File: rtl/vts_slot_seq.sv
module vts_slot_seq
   import vts_pkg::*;
#(
   parameter int IDW = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [IDW-1:0] stn_count,
   input  logic           carrier,
   input  logic           frame_end,
   input  logic           slot_done,
   output logic           timer_clr,
   output logic           timer_run,
   output logic           slot_start,
   output logic [IDW-1:0] slot_num
);
   vts_state_e     state;
   logic [IDW-1:0] sender;

   function automatic logic [IDW-1:0] succ(input logic [IDW-1:0] k,
                                           input logic [IDW-1:0] n);
      return (k >= n) ? IDW'(1) : k + 1'b1;
   endfunction

   assign timer_clr = frame_end || (state != VTS_COUNT);
   assign timer_run = (state == VTS_COUNT) && !carrier && !frame_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= VTS_SYNC;
         sender     <= '0;
         slot_num   <= '0;
         slot_start <= 1'b0;
      end else if (frame_end) begin
         state      <= VTS_COUNT;
         slot_num   <= succ(sender, stn_count);
         slot_start <= 1'b1;
      end else if (state == VTS_COUNT && carrier) begin
         state      <= VTS_BUSY;
         sender     <= slot_num;
         slot_start <= 1'b0;
      end else if (state == VTS_COUNT && slot_done) begin
         slot_num   <= succ(slot_num, stn_count);
         slot_start <= 1'b1;
      end else begin
         slot_start <= 1'b0;
      end
   end

   // R2
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> (slot_start && slot_num != '0));
   // R4
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(frame_end) && slot_num != $past(slot_num))
         |-> (slot_num == IDW'(1) || slot_num == $past(slot_num) + 1'b1));
   // R7
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == VTS_BUSY && !frame_end) |=> $stable(slot_num));
   // R1
   sync_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == VTS_SYNC) |-> (slot_num == '0 && !slot_start));
endmodule

// File: rtl/vts_grant_gen.sv
module vts_grant_gen #(
   parameter int IDW       = 4,
   parameter bit GRANT_REG = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           slot_start,
   input  logic [IDW-1:0] slot_num,
   input  logic [IDW-1:0] my_id,
   input  logic           pending,
   input  logic           carrier,
   output logic           tx_grant
);
   logic win;
   assign win = slot_start && (slot_num == my_id) && pending && !carrier;

   generate
      if (GRANT_REG) begin : g_reg
         logic grant_q;
         always_ff @(posedge clk) begin
            if (!rst_n) grant_q <= 1'b0;
            else        grant_q <= win;
         end
         assign tx_grant = grant_q;

         // R5
         grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tx_grant |=> !tx_grant);
         // R6
         grant_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tx_grant |-> ($past(pending) && !$past(carrier)));
      end else begin : g_comb
         assign tx_grant = win;
      end
   endgenerate
endmodule

// File: rtl/vts_arbiter.sv
module vts_arbiter #(
   parameter int IDW            = 4,
   parameter int LENW           = 8,
   parameter int SLOT_TICKS_RST = 54,
   parameter bit GRANT_REG      = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [IDW-1:0]  my_id,
   input  logic [IDW-1:0]  stn_count,
   input  logic            carrier,
   input  logic            frame_end,
   input  logic            pending,
   input  logic            tick,
   input  logic            cfg_we,
   input  logic [LENW-1:0] cfg_len,
   output logic            tx_grant,
   output logic [IDW-1:0]  token_slot
);
   generate
      if (IDW < 1 || IDW > 16) begin : g_bad_idw
         $error("vts_arbiter: IDW out of range");
      end
      if (SLOT_TICKS_RST < 1 || SLOT_TICKS_RST >= (1 << LENW)) begin : g_bad_len
         $error("vts_arbiter: SLOT_TICKS_RST does not fit LENW");
      end
   endgenerate

   logic timer_clr, timer_run, slot_done, slot_start;

   vts_slot_timer #(.LENW(LENW), .SLOT_TICKS_RST(SLOT_TICKS_RST)) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (timer_clr),
      .run       (timer_run),
      .tick      (tick),
      .cfg_we    (cfg_we),
      .cfg_len   (cfg_len),
      .slot_done (slot_done)
   );

   vts_slot_seq #(.IDW(IDW)) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .stn_count  (stn_count),
      .carrier    (carrier),
      .frame_end  (frame_end),
      .slot_done  (slot_done),
      .timer_clr  (timer_clr),
      .timer_run  (timer_run),
      .slot_start (slot_start),
      .slot_num   (token_slot)
   );

   vts_grant_gen #(.IDW(IDW), .GRANT_REG(GRANT_REG)) i_grant (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot_start (slot_start),
      .slot_num   (token_slot),
      .my_id      (my_id),
      .pending    (pending),
      .carrier    (carrier),
      .tx_grant   (tx_grant)
   );

   // R6
   grant_own_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_grant |-> ($past(token_slot) == $past(my_id)));
endmodule

// File: tb/test_vts_arbiter.sv
module test_vts_arbiter;
   localparam int IDW = 4, LENW = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [IDW-1:0] my_id = 4, stn_count = 7;
   logic carrier = 0, frame_end = 0, pending = 0, tick = 0, cfg_we = 0;
   logic [LENW-1:0] cfg_len = 0;
   logic tx_grant;
   logic [IDW-1:0] token_slot;

   int total = 0, bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   vts_arbiter i_vts_arbiter (
      .clk(clk), .rst_n(rst_n), .my_id(my_id), .stn_count(stn_count),
      .carrier(carrier), .frame_end(frame_end), .pending(pending), .tick(tick),
      .cfg_we(cfg_we), .cfg_len(cfg_len), .tx_grant(tx_grant), .token_slot(token_slot));

   // tick every second clock
   logic tdiv = 0;
   always @(negedge clk) begin
      tdiv <= ~tdiv;
      tick <= tdiv;
   end

   function automatic int nx(int k, int n);
      return (k >= n) ? 1 : k + 1;
   endfunction

   // cycle-level reference model built from the requirements
   int m_state = 0, m_slot = 0, m_sender = 0, m_tc = 0, m_len = 54;
   bit m_start = 0, m_grant = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_state <= 0; m_slot <= 0; m_sender <= 0; m_tc <= 0;
         m_len <= 54; m_start <= 0; m_grant <= 0;
      end else begin
         if (cfg_we && cfg_len != 0) m_len <= int'(cfg_len);
         m_grant <= m_start && (m_slot == int'(my_id)) && pending && !carrier;
         if (frame_end) begin
            m_state <= 1; m_slot <= nx(m_sender, int'(stn_count));
            m_start <= 1; m_tc <= 0;
         end else if (m_state == 1 && carrier) begin
            m_state <= 2; m_sender <= m_slot; m_start <= 0; m_tc <= 0;
         end else if (m_state == 1 && tick) begin
            if (m_tc + 1 >= m_len) begin
               m_slot <= nx(m_slot, int'(stn_count)); m_start <= 1; m_tc <= 0;
            end else begin
               m_tc <= m_tc + 1; m_start <= 0;
            end
         end else begin
            m_start <= 0;
         end
      end
   end

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check("R3 token_slot vs model", int'(token_slot), m_slot);
         check("R5 tx_grant vs model", int'(tx_grant), int'(m_grant));
      end
   end

   task automatic step(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic fe_pulse();
      frame_end = 1; step(1); frame_end = 0;
   endtask

   task automatic wait_slot(int v);
      int guard = 0;
      while (int'(token_slot) != v && guard < 4000) begin step(1); guard++; end
      if (guard >= 4000) check("R3 wait for slot", int'(token_slot), v);
   endtask

   // cycles between two consecutive slot changes, away from the phase of the first
   task automatic measure_slot(output int cyc);
      int s;
      s = int'(token_slot);
      while (int'(token_slot) == s) step(1);
      s = int'(token_slot);
      cyc = 0;
      while (int'(token_slot) == s && cyc < 1000) begin step(1); cyc++; end
   endtask

   initial begin
      int c, g;
      step(5);
      check("R1 reset token_slot", int'(token_slot), 0);
      check("R1 reset tx_grant", int'(tx_grant), 0);
      rst_n = 1;
      carrier = 1; step(6); carrier = 0; step(14);
      check("R1 no counting before frame end", int'(token_slot), 0);

      fe_pulse();
      check("R2 first count starts at slot 1", int'(token_slot), 1);
      measure_slot(c);
      check("R9 reset slot length 54 ticks", c, 108);

      cfg_len = 0; cfg_we = 1; step(1); cfg_we = 0;
      measure_slot(c);
      check("R10 zero write ignored", c, 108);
      cfg_len = 3; cfg_we = 1; step(1); cfg_we = 0;
      measure_slot(c); measure_slot(c);
      check("R3 slot of 3 ticks", c, 6);

      wait_slot(7); wait_slot(1);
      check("R4 wrap from count to 1", int'(token_slot), 1);

      pending = 1;
      wait_slot(4);
      check("R5 no grant in start cycle", int'(tx_grant), 0);
      step(1);
      check("R5 grant one clock after own slot begins", int'(tx_grant), 1);
      step(1);
      check("R5 grant lasts one clock", int'(tx_grant), 0);

      pending = 0; g = 0;
      wait_slot(3);
      for (int i = 0; i < 16; i++) begin step(1); g += int'(tx_grant); end
      check("R6 no grant without pending", g, 0);
      check("R6 silent slot passes", int'(token_slot) >= 5 ? 1 : 0, 1);

      wait_slot(2);
      carrier = 1; step(20);
      check("R7 slot frozen under carrier", int'(token_slot), 2);
      carrier = 0; pending = 1; fe_pulse();
      check("R8 resume after sender 2", int'(token_slot), 3);
      wait_slot(4); step(1);
      check("R8 station 4 gets next right", int'(tx_grant), 1);

      wait_slot(4);
      carrier = 1; step(1);
      check("R6 carrier suppresses grant", int'(tx_grant), 0);
      step(8); carrier = 0; fe_pulse();
      check("R8 resume after own slot", int'(token_slot), 5);

      // constrained random traffic
      void'($urandom(32'h1901));
      for (int it = 0; it < 1500; it++) begin
         int r;
         r = int'($urandom_range(0, 99));
         pending = ($urandom_range(0, 2) != 0);
         if (r < 30) begin
            carrier = 1; step(int'($urandom_range(1, 12)));
            carrier = 0; fe_pulse();
         end else if (r < 35) begin
            cfg_len = LENW'($urandom_range(0, 5)); cfg_we = 1; step(1); cfg_we = 0;
         end else if (r < 39) begin
            stn_count = IDW'($urandom_range(1, 9));
            my_id = IDW'($urandom_range(1, 9));
            step(1);
         end else begin
            step(int'($urandom_range(1, 20)));
         end
      end
      carrier = 0; pending = 0;
      step(2);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule